// File: doc/BRIEF.md
# Chirp Frame Symbol Sequencer

This block produces, one step at a time, the symbol sequence of a single chirp-spread-spectrum frame for a downstream chirp modulator. A start strobe captures the frame settings. These are the spreading factor, the number of plain up-chirps that open the frame, two sync symbol values, whether a fixed-length header is present, and the payload symbol count. The block then walks a fixed order of segments: the preamble up-chirps, the two sync symbols, two and a quarter down-chirps, eight header data symbols when the header is enabled, and the payload data symbols.

Each step leaves on a valid/ready port. A step carries a chirp kind, a symbol value and a duration in quarter-symbol units, so the fractional down-chirp segment is a full-length step followed by a one-quarter step. The block pulls header and payload values from an upstream valid/ready port and trims them to the spreading-factor width. It takes upstream values only while a header or payload symbol is due and the output slot can take it.

When the last step of the frame has been taken downstream, a one-cycle completion pulse follows, and the block is ready for the next start. A start strobe that arrives during a frame is ignored.

Top module: `chirp_frame_seq`

## Requirements
- R1: After reset, out_valid_o, src_ready_o, busy_o and done_o are all 0.
- R2: A frame opens with exactly cfg_pre_len_i steps of kind up (code 0), value 0, length 4 quarters; a length of 0 gives no up steps.
- R3: Next come exactly two steps of kind data (code 2), length 4, carrying the first and then the second sync value, each trimmed to the spreading-factor width.
- R4: Next come three steps of kind down (code 1), value 0, with lengths 4, 4 and then 1 quarter. A length other than 4 appears only on a down step.
- R5: With cfg_explicit_i = 1, exactly 8 header steps of kind data follow, taken in order from the upstream port. With cfg_explicit_i = 0, no header steps are sent.
- R6: Exactly cfg_pay_len_i payload steps of kind data follow, taken in upstream order; a count of 0 ends the frame after the preceding segment.
- R7: The spreading factor is captured at start and clamped to 6..12. Every data step value has all bits at or above that width forced to 0.
- R8: While out_valid_o is 1 and out_ready_i is 0, the output step stays valid and unchanged on the next cycle.
- R9: src_ready_o is 1 only while a header or payload symbol is due and the output slot is empty or being taken. A frame pulls exactly as many upstream values as it sends header plus payload steps.
- R10: done_o is high for exactly one cycle, the cycle right after the last step of the frame is taken; busy_o is 0 from then until the next start.
- R11: A start strobe during a frame has no effect: the frame's remaining steps and settings are unchanged and no new frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| cfg_sf_i | input | 4 | Spreading factor, clamped to 6..12 |
| cfg_pre_len_i | input | PRE_W | Number of preamble up-chirps |
| cfg_sync0_i | input | SYM_W | First sync symbol value |
| cfg_sync1_i | input | SYM_W | Second sync symbol value |
| cfg_explicit_i | input | 1 | 1 sends the 8-symbol header |
| cfg_pay_len_i | input | LEN_W | Number of payload symbols |
| busy_o | output | 1 | A frame is in progress |
| done_o | output | 1 | One-cycle frame completion pulse |
| src_valid_i | input | 1 | Upstream symbol valid |
| src_ready_o | output | 1 | Upstream symbol taken this cycle if valid |
| src_data_i | input | SYM_W | Upstream header/payload symbol value |
| out_valid_o | output | 1 | Output step valid |
| out_ready_i | input | 1 | Downstream takes the step |
| out_kind_o | output | 2 | Chirp kind: 0 up, 1 down, 2 data |
| out_value_o | output | SYM_W | Symbol value |
| out_qlen_o | output | 3 | Step length in quarter symbols |

## Verification
The embedded properties check the rules that hold every cycle. These are: a stalled step stays stable, upstream values are pulled only when the output slot has room, and only down steps may be shorter than a full symbol. They also check that non-data steps carry value 0, that data values respect the spreading-factor width, that the completion pulse lasts one cycle, and that no new preamble starts mid-frame. The directed scenarios cover what no single-cycle rule can show. They check the order and count of every segment against a model, the absence of a header in implicit mode, and empty preamble and payload cases. They also cover the clamping of out-of-range spreading factors, a start strobe arriving mid-frame, and the exact cycle of the completion pulse under several backpressure and source-gap patterns.

// File: rtl/chirp_seq_pkg.sv
package chirp_seq_pkg;

  typedef enum logic [1:0] {
    CK_UP   = 2'd0,
    CK_DOWN = 2'd1,
    CK_DATA = 2'd2
  } chirp_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_PREAMBLE = 3'd1,
    ST_SYNC     = 3'd2,
    ST_DOWN     = 3'd3,
    ST_HEADER   = 3'd4,
    ST_PAYLOAD  = 3'd5,
    ST_DONE     = 3'd6
  } seq_state_e;

  localparam int          QLEN_W       = 3;
  localparam logic [2:0]  QLEN_FULL    = 3'd4;
  localparam logic [2:0]  QLEN_QUARTER = 3'd1;
  localparam logic [3:0]  SF_LOW       = 4'd6;
  localparam logic [3:0]  SF_HIGH      = 4'd12;

endpackage

// File: rtl/chirp_seq_cfg.sv
module chirp_seq_cfg
  import chirp_seq_pkg::*;
#(
  parameter int SYM_W = 12,
  parameter int PRE_W = 16,
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  logic [3:0]       sf_i,
  input  logic [PRE_W-1:0] pre_len_i,
  input  logic [SYM_W-1:0] sync0_i,
  input  logic [SYM_W-1:0] sync1_i,
  input  logic             explicit_i,
  input  logic [LEN_W-1:0] pay_len_i,
  output logic [SYM_W-1:0] mask_o,
  output logic [SYM_W-1:0] sync0_o,
  output logic [SYM_W-1:0] sync1_o,
  output logic [PRE_W-1:0] pre_len_o,
  output logic             explicit_o,
  output logic [LEN_W-1:0] pay_len_o
);

  logic [3:0]       sf_clamped;
  logic [SYM_W-1:0] mask_d;
  logic [SYM_W-1:0] mask_q;
  logic [SYM_W-1:0] sync0_q, sync1_q;
  logic [PRE_W-1:0] pre_len_q;
  logic             explicit_q;
  logic [LEN_W-1:0] pay_len_q;

  // Clamp the spreading factor into its legal range.
  always_comb begin
    if (sf_i < SF_LOW) begin
      sf_clamped = SF_LOW;
    end else if (sf_i > SF_HIGH) begin
      sf_clamped = SF_HIGH;
    end else begin
      sf_clamped = sf_i;
    end
  end

  // Width mask: one bit per symbol bit below the spreading factor.
  always_comb begin
    for (int i = 0; i < SYM_W; i++) begin
      mask_d[i] = (i < int'(sf_clamped));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q     <= '0;
      sync0_q    <= '0;
      sync1_q    <= '0;
      pre_len_q  <= '0;
      explicit_q <= 1'b0;
      pay_len_q  <= '0;
    end else if (capture_i) begin
      mask_q     <= mask_d;
      sync0_q    <= sync0_i & mask_d;
      sync1_q    <= sync1_i & mask_d;
      pre_len_q  <= pre_len_i;
      explicit_q <= explicit_i;
      pay_len_q  <= pay_len_i;
    end
  end

  assign mask_o     = mask_q;
  assign sync0_o    = sync0_q;
  assign sync1_o    = sync1_q;
  assign pre_len_o  = pre_len_q;
  assign explicit_o = explicit_q;
  assign pay_len_o  = pay_len_q;

endmodule

// File: rtl/chirp_seq_ctrl.sv
module chirp_seq_ctrl
  import chirp_seq_pkg::*;
#(
  parameter int SYM_W    = 12,
  parameter int PRE_W    = 16,
  parameter int LEN_W    = 8,
  parameter int HDR_SYMS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              room_i,
  input  logic [PRE_W-1:0]  pre_len_i,
  input  logic [SYM_W-1:0]  sync0_i,
  input  logic [SYM_W-1:0]  sync1_i,
  input  logic              explicit_i,
  input  logic [LEN_W-1:0]  pay_len_i,
  input  logic [SYM_W-1:0]  mask_i,
  input  logic              src_valid_i,
  input  logic [SYM_W-1:0]  src_data_i,
  output logic              src_ready_o,
  output logic              load_o,
  output chirp_kind_e       kind_o,
  output logic [SYM_W-1:0]  value_o,
  output logic [QLEN_W-1:0] qlen_o,
  output logic              idle_o,
  output logic              done_o
);

  localparam int CNT_RAW = (PRE_W > LEN_W) ? PRE_W : LEN_W;
  localparam int CNT_W   = (CNT_RAW > 4) ? CNT_RAW : 4;

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             cnt_en;
  logic             done_q, done_d;
  logic             pay_empty;
  logic             src_fire;

  assign cnt_inc   = cnt_q + CNT_W'(1);
  assign pay_empty = (pay_len_i == '0);
  assign src_fire  = room_i && src_valid_i;

  // Next-state and step generation.
  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    done_d      = 1'b0;
    load_o      = 1'b0;
    kind_o      = CK_UP;
    value_o     = '0;
    qlen_o      = QLEN_FULL;
    src_ready_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_PREAMBLE;
          cnt_d   = '0;
        end
      end
      ST_PREAMBLE: begin
        if (pre_len_i == '0) begin
          state_d = ST_SYNC;
          cnt_d   = '0;
        end else if (room_i) begin
          load_o = 1'b1;
          kind_o = CK_UP;
          if (cnt_inc == CNT_W'(pre_len_i)) begin
            state_d = ST_SYNC;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_inc;
          end
        end
      end
      ST_SYNC: begin
        if (room_i) begin
          load_o  = 1'b1;
          kind_o  = CK_DATA;
          value_o = cnt_q[0] ? sync1_i : sync0_i;
          if (cnt_q[0]) begin
            state_d = ST_DOWN;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_inc;
          end
        end
      end
      ST_DOWN: begin
        if (room_i) begin
          load_o = 1'b1;
          kind_o = CK_DOWN;
          if (cnt_q == CNT_W'(2)) begin
            qlen_o = QLEN_QUARTER;
            cnt_d  = '0;
            if (explicit_i) begin
              state_d = ST_HEADER;
            end else if (pay_empty) begin
              state_d = ST_DONE;
            end else begin
              state_d = ST_PAYLOAD;
            end
          end else begin
            cnt_d = cnt_inc;
          end
        end
      end
      ST_HEADER: begin
        src_ready_o = room_i;
        if (src_fire) begin
          load_o  = 1'b1;
          kind_o  = CK_DATA;
          value_o = src_data_i & mask_i;
          if (cnt_inc == CNT_W'(HDR_SYMS)) begin
            cnt_d   = '0;
            state_d = pay_empty ? ST_DONE : ST_PAYLOAD;
          end else begin
            cnt_d = cnt_inc;
          end
        end
      end
      ST_PAYLOAD: begin
        src_ready_o = room_i;
        if (src_fire) begin
          load_o  = 1'b1;
          kind_o  = CK_DATA;
          value_o = src_data_i & mask_i;
          if (cnt_inc == CNT_W'(pay_len_i)) begin
            cnt_d   = '0;
            state_d = ST_DONE;
          end else begin
            cnt_d = cnt_inc;
          end
        end
      end
      ST_DONE: begin
        // The last step is in the output slot; finish once it leaves.
        if (room_i) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  assign cnt_en = (cnt_d != cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign idle_o = (state_q == ST_IDLE);
  assign done_o = done_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R10

  AST_DONE_IN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (state_q == ST_IDLE)); // R10

  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && state_q != ST_PREAMBLE) |=> (state_q != ST_PREAMBLE)); // R11

  AST_HEADER_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HEADER) |-> (cnt_q < CNT_W'(HDR_SYMS))); // R5

endmodule

// File: rtl/chirp_seq_outreg.sv
module chirp_seq_outreg
  import chirp_seq_pkg::*;
#(
  parameter int SYM_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  chirp_kind_e       kind_i,
  input  logic [SYM_W-1:0]  value_i,
  input  logic [QLEN_W-1:0] qlen_i,
  input  logic              ready_i,
  output logic              valid_o,
  output chirp_kind_e       kind_o,
  output logic [SYM_W-1:0]  value_o,
  output logic [QLEN_W-1:0] qlen_o,
  output logic              room_o
);

  logic              valid_q, valid_d;
  chirp_kind_e       kind_q;
  logic [SYM_W-1:0]  value_q;
  logic [QLEN_W-1:0] qlen_q;

  assign room_o = !valid_q || ready_i;

  always_comb begin
    if (load_i) begin
      valid_d = 1'b1;
    end else if (ready_i) begin
      valid_d = 1'b0;
    end else begin
      valid_d = valid_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q  <= CK_UP;
      value_q <= '0;
      qlen_q  <= '0;
    end else if (load_i) begin
      kind_q  <= kind_i;
      value_q <= value_i;
      qlen_q  <= qlen_i;
    end
  end

  assign valid_o = valid_q;
  assign kind_o  = kind_q;
  assign value_o = value_q;
  assign qlen_o  = qlen_q;

  AST_HOLD_STALLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !ready_i) |=> (valid_q && $stable(kind_q) && $stable(value_q) && $stable(qlen_q))); // R8

  AST_NO_OVERWRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (!valid_q || ready_i)); // R8

  AST_SHORT_ONLY_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && qlen_q != QLEN_FULL) |-> (kind_q == CK_DOWN && qlen_q == QLEN_QUARTER)); // R4

  AST_PLAIN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && kind_q != CK_DATA) |-> (value_q == '0)); // R2

endmodule

// File: rtl/chirp_frame_seq.sv
module chirp_frame_seq
  import chirp_seq_pkg::*;
#(
  parameter int SYM_W    = 12,
  parameter int PRE_W    = 16,
  parameter int LEN_W    = 8,
  parameter int HDR_SYMS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [3:0]       cfg_sf_i,
  input  logic [PRE_W-1:0] cfg_pre_len_i,
  input  logic [SYM_W-1:0] cfg_sync0_i,
  input  logic [SYM_W-1:0] cfg_sync1_i,
  input  logic             cfg_explicit_i,
  input  logic [LEN_W-1:0] cfg_pay_len_i,
  output logic             busy_o,
  output logic             done_o,
  input  logic             src_valid_i,
  output logic             src_ready_o,
  input  logic [SYM_W-1:0] src_data_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [1:0]       out_kind_o,
  output logic [SYM_W-1:0] out_value_o,
  output logic [2:0]       out_qlen_o
);

  logic              idle;
  logic              capture;
  logic [SYM_W-1:0]  mask;
  logic [SYM_W-1:0]  sync0, sync1;
  logic [PRE_W-1:0]  pre_len;
  logic              explicit_hdr;
  logic [LEN_W-1:0]  pay_len;
  logic              room;
  logic              step_load;
  chirp_kind_e       step_kind;
  logic [SYM_W-1:0]  step_value;
  logic [QLEN_W-1:0] step_qlen;
  chirp_kind_e       out_kind;

  assign capture = start_i && idle;

  chirp_seq_cfg #(
    .SYM_W (SYM_W),
    .PRE_W (PRE_W),
    .LEN_W (LEN_W)
  ) cfg_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .capture_i  (capture),
    .sf_i       (cfg_sf_i),
    .pre_len_i  (cfg_pre_len_i),
    .sync0_i    (cfg_sync0_i),
    .sync1_i    (cfg_sync1_i),
    .explicit_i (cfg_explicit_i),
    .pay_len_i  (cfg_pay_len_i),
    .mask_o     (mask),
    .sync0_o    (sync0),
    .sync1_o    (sync1),
    .pre_len_o  (pre_len),
    .explicit_o (explicit_hdr),
    .pay_len_o  (pay_len)
  );

  chirp_seq_ctrl #(
    .SYM_W    (SYM_W),
    .PRE_W    (PRE_W),
    .LEN_W    (LEN_W),
    .HDR_SYMS (HDR_SYMS)
  ) ctrl_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .room_i      (room),
    .pre_len_i   (pre_len),
    .sync0_i     (sync0),
    .sync1_i     (sync1),
    .explicit_i  (explicit_hdr),
    .pay_len_i   (pay_len),
    .mask_i      (mask),
    .src_valid_i (src_valid_i),
    .src_data_i  (src_data_i),
    .src_ready_o (src_ready_o),
    .load_o      (step_load),
    .kind_o      (step_kind),
    .value_o     (step_value),
    .qlen_o      (step_qlen),
    .idle_o      (idle),
    .done_o      (done_o)
  );

  chirp_seq_outreg #(
    .SYM_W (SYM_W)
  ) out_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (step_load),
    .kind_i  (step_kind),
    .value_i (step_value),
    .qlen_i  (step_qlen),
    .ready_i (out_ready_i),
    .valid_o (out_valid_o),
    .kind_o  (out_kind),
    .value_o (out_value_o),
    .qlen_o  (out_qlen_o),
    .room_o  (room)
  );

  assign out_kind_o = out_kind;
  assign busy_o     = !idle;

  AST_VALUE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ((out_value_o & ~mask) == '0)); // R7

  AST_PULL_WITH_ROOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_ready_o |-> (!out_valid_o || out_ready_i)); // R9

endmodule

// File: tb/chirp_frame_seq_tb_top.sv
module chirp_frame_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int SYM_W      = 12;
  localparam int PRE_W      = 16;
  localparam int LEN_W      = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start;
  logic [3:0]       cfg_sf;
  logic [PRE_W-1:0] cfg_pre;
  logic [SYM_W-1:0] cfg_s0, cfg_s1;
  logic             cfg_expl;
  logic [LEN_W-1:0] cfg_plen;
  logic             busy, done;
  logic             src_valid, src_ready;
  logic [SYM_W-1:0] src_data;
  logic             out_valid, out_ready;
  logic [1:0]       out_kind;
  logic [SYM_W-1:0] out_value;
  logic [2:0]       out_qlen;

  int checks   = 0;
  int failures = 0;

  logic [1:0]       ek [256];
  logic [SYM_W-1:0] ev [256];
  logic [2:0]       eq [256];
  string            er [256];
  int               ecount;
  logic [7:0]       lfsr = 8'h5B;

  always #(CLK_PERIOD/2) clk = ~clk;

  chirp_frame_seq dut_i (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start),
    .cfg_sf_i (cfg_sf), .cfg_pre_len_i (cfg_pre), .cfg_sync0_i (cfg_s0),
    .cfg_sync1_i (cfg_s1), .cfg_explicit_i (cfg_expl), .cfg_pay_len_i (cfg_plen),
    .busy_o (busy), .done_o (done),
    .src_valid_i (src_valid), .src_ready_o (src_ready), .src_data_i (src_data),
    .out_valid_o (out_valid), .out_ready_i (out_ready),
    .out_kind_o (out_kind), .out_value_o (out_value), .out_qlen_o (out_qlen)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [SYM_W-1:0] src_word(input int i);
    return SYM_W'(((i * 613) + 29) ^ 32'hC3A);
  endfunction

  task automatic push(input logic [1:0] k, input logic [SYM_W-1:0] v, input logic [2:0] q, input string r);
    ek[ecount] = k; ev[ecount] = v; eq[ecount] = q; er[ecount] = r;
    ecount++;
  endtask

  // Expected step list built from the requirements.
  task automatic build_expected(input int sf, input int pre, input int s0, input int s1,
                                input bit expl, input int plen, input int base);
    int sfc;
    logic [SYM_W-1:0] m;
    sfc = (sf < 6) ? 6 : ((sf > 12) ? 12 : sf);
    m = SYM_W'((1 << sfc) - 1);
    ecount = 0;
    for (int i = 0; i < pre; i++) push(2'd0, '0, 3'd4, "R2");
    push(2'd2, SYM_W'(s0) & m, 3'd4, "R3");
    push(2'd2, SYM_W'(s1) & m, 3'd4, "R3");
    push(2'd1, '0, 3'd4, "R4");
    push(2'd1, '0, 3'd4, "R4");
    push(2'd1, '0, 3'd1, "R4");
    if (expl) for (int i = 0; i < 8; i++) push(2'd2, src_word(base + i) & m, 3'd4, "R5");
    for (int i = 0; i < plen; i++) push(2'd2, src_word(base + (expl ? 8 : 0) + i) & m, 3'd4, "R6");
  endtask

  // One frame: rmode 0 always ready, 1 alternating, 2 pseudo-random;
  // vmode 0 source always valid, 1 source with gaps; mid_start > 0 pulses start mid-frame.
  task automatic run_frame(input string name, input int sf, input int pre, input int s0, input int s1,
                           input bit expl, input int plen, input int rmode, input int vmode,
                           input int mid_start);
    int got, srcidx, cyc, nsrc;
    bit done_seen, last_prev, hold_pend;
    logic [1:0] hk; logic [SYM_W-1:0] hv; logic [2:0] hq;
    build_expected(sf, pre, s0, s1, expl, plen, 100);
    nsrc = (expl ? 8 : 0) + plen;
    @(negedge clk);
    cfg_sf = 4'(sf); cfg_pre = PRE_W'(pre); cfg_s0 = SYM_W'(s0); cfg_s1 = SYM_W'(s1);
    cfg_expl = expl; cfg_plen = LEN_W'(plen); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // Settings must have been captured at start (R7, R2): disturb the inputs.
    cfg_sf = 4'd6; cfg_pre = PRE_W'(1); cfg_s0 = '1; cfg_s1 = '1; cfg_expl = ~expl; cfg_plen = LEN_W'(9);
    got = 0; srcidx = 0; cyc = 0; done_seen = 0; last_prev = 0; hold_pend = 0;
    hk = '0; hv = '0; hq = '0;
    while (!done_seen && cyc < 3000) begin
      if (done) begin
        check(last_prev && got == ecount, "R10", {name, " done pulse right after last step"}, got, ecount);
        done_seen = 1;
      end else begin
        if (hold_pend)
          check(out_valid && out_kind == hk && out_value == hv && out_qlen == hq, "R8",
                {name, " stalled step held"}, int'(out_value), int'(hv));
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        case (rmode)
          0: out_ready = 1'b1;
          1: out_ready = cyc[0];
          default: out_ready = lfsr[0] | lfsr[2];
        endcase
        src_valid = (srcidx < nsrc) && (vmode == 0 || (cyc % 3) != 0);
        src_data  = src_word(100 + srcidx);
        if (mid_start > 0 && cyc == mid_start) begin
          start = 1'b1; cfg_sf = 4'd12; cfg_pre = PRE_W'(3); cfg_expl = 1'b1; cfg_plen = LEN_W'(2);
        end else begin
          start = 1'b0;
        end
        #1;
        last_prev = 0; hold_pend = 0;
        if (out_valid && out_ready) begin
          if (got < ecount) begin
            checks++;
            if (out_kind !== ek[got] || out_value !== ev[got] || out_qlen !== eq[got]) begin
              failures++;
              $display("FAIL %s %s step %0d: actual kind=%0d val=%h qlen=%0d expected kind=%0d val=%h qlen=%0d",
                       er[got], name, got, out_kind, out_value, out_qlen, ek[got], ev[got], eq[got]);
            end
          end else begin
            check(0, "R6", {name, " extra step after frame end"}, got + 1, ecount);
          end
          got++;
          last_prev = (got == ecount);
        end else if (out_valid) begin
          hold_pend = 1; hk = out_kind; hv = out_value; hq = out_qlen;
        end
        if (src_valid && src_ready) srcidx++;
        cyc++;
        @(negedge clk);
      end
    end
    start = 1'b0; src_valid = 1'b0;
    check(done_seen, "R10", {name, " frame completed before timeout"}, int'(done_seen), 1);
    check(got == ecount, "R6", {name, " step count"}, got, ecount);
    check(srcidx == nsrc, "R9", {name, " upstream values pulled"}, srcidx, nsrc);
    @(negedge clk);
    check(!done && !busy && !out_valid, "R11", {name, " idle after done, no extra frame"},
          int'({done, busy, out_valid}), 0);
  endtask

  task automatic test_reset();
    rst_n = 1'b0; start = 1'b0; src_valid = 1'b0; out_ready = 1'b0; src_data = '0;
    cfg_sf = '0; cfg_pre = '0; cfg_s0 = '0; cfg_s1 = '0; cfg_expl = 1'b0; cfg_plen = '0;
    repeat (3) @(negedge clk);
    check(!out_valid && !src_ready && !busy && !done, "R1", "outputs in reset",
          int'({out_valid, src_ready, busy, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && !src_ready && !busy && !done, "R1", "outputs after reset release",
          int'({out_valid, src_ready, busy, done}), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    test_reset();
    // R2 R3 R5 R6: explicit header, full flow control.
    run_frame("explicit_sf7", 7, 8, 'h192, 'h2B4, 1'b1, 5, 0, 0, 0);
    // R5 implicit skip, R8 stalls, source gaps.
    run_frame("implicit_sf12_stall", 12, 4, 'hABC, 'h123, 1'b0, 3, 1, 1, 0);
    // R2 empty preamble, R6 empty payload, R7 clamp low.
    run_frame("empty_sf3", 3, 0, 'hFFF, 'hFC1, 1'b1, 0, 2, 0, 0);
    // R4 frame ending on the quarter down step, R7 clamp high.
    run_frame("quarter_end_sf15", 15, 2, 'hFFF, 'h800, 1'b0, 0, 2, 1, 0);
    // R11 start strobe mid-frame ignored.
    run_frame("mid_start_sf9", 9, 6, 'h1FF, 'h0AA, 1'b1, 4, 2, 1, 7);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule